// File: doc/BRIEF.md
# Peripheral Request Time-out Monitor

This block sits beside a DMA channel arbiter. It watches channels that are waiting for a handshake request from a peripheral. For each channel, a countdown is loaded with a programmed period. The countdown steps down on a tick that comes from the system clock through a power-of-two prescaler, and each channel picks its own tick rate. When a peripheral request arrives, the countdown restarts from the period. If the countdown reaches zero before a request arrives, a sticky time-out flag is set for that channel. Software clears the flag by writing a one to it.

Each channel has an enable and a separate interrupt enable. The countdown runs only while the channel is enabled and the arbiter reports that the channel is active and waiting. At all other times the countdown is held at the period value. A single interrupt output combines the flags whose interrupt enables are set. The arbitration and the data movement are handled elsewhere. The monitor only observes the waiting state and the requests.

Top module: `tmo_req_monitor`

## Requirements
- R1: After reset, every time-out flag and the interrupt output are 0.
- R2: A channel's 3-bit prescaler select s (0 to 7) gives a tick every 2^(BASE_SHIFT+s) clock cycles, with BASE_SHIFT = 8 by default. With a period P of 1 or more and no requests, the flag rises after exactly P ticks. Measured in clock edges after the channel is armed, this falls in the window from (P-1)*2^(BASE_SHIFT+s)+1 to P*2^(BASE_SHIFT+s).
- R3: Each peripheral request on an armed channel reloads the countdown with the period. Requests that come more often than the countdown can expire keep the flag at 0.
- R4: The countdown runs only when the channel's enable and its waiting input are both 1. Otherwise it holds the period value, and the flag never rises.
- R5: The flag is sticky. A one on the channel's bit of `flag_clr` clears it at the next clock edge. A zero bit leaves it unchanged.
- R6: After it expires, the countdown stays at zero. A cleared flag does not rise again until a request or a re-arm reloads the countdown, which then expires again after the full period.
- R7: `irq` is the OR, over all channels, of each flag ANDed with that channel's interrupt enable. `irq` is combinational from the flag and the enable.
- R8: A period of zero never sets the flag.
- R9: Channels are independent. The expiry of one channel does not change another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | NCH | Per-channel time-out enable |
| cfg_irq_en | input | NCH | Per-channel interrupt enable |
| cfg_psc | input | NCH*SEL_W | Per-channel prescaler select, channel c in bits [c*SEL_W +: SEL_W] |
| cfg_period | input | NCH*PERIOD_W | Per-channel period in ticks, channel c in bits [c*PERIOD_W +: PERIOD_W] |
| ch_waiting | input | NCH | Channel is active and waiting for a peripheral request |
| periph_req | input | NCH | Peripheral request accepted for the channel (one-cycle pulse) |
| flag_clr | input | NCH | Write-one-to-clear pulse for the time-out flags |
| tmo_flag | output | NCH | Sticky time-out flags |
| irq | output | 1 | Combined time-out interrupt |

## Verification
The bench uses a reduced prescaler base, so that every prescaler select can be swept with periods 1, 2 and 3. It checks that the measured expiry edge falls inside the arithmetic window. Because adjacent selects double the window, an off-by-one in the select or in the period is caught.

Several other patterns are exercised:
- Requests spaced closer than the period show that the countdown reloads on each request.
- Disabled channels and non-waiting channels show that the countdown is gated.
- Clear pulses to one channel and then the other separate a genuine clear from cross-channel effects.
- A long wait after a clear shows that the countdown stays parked at zero.
- Interrupt-enable toggles and a zero period cover the remaining cases.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
   // Number of prescale taps for a given select width.
   function automatic int unsigned tap_count(input int unsigned sel_w);
      return 1 << sel_w;
   endfunction

   // Width of the free-running prescale counter.
   function automatic int unsigned prescale_width(input int unsigned base_shift,
                                                  input int unsigned sel_w);
      return base_shift + tap_count(sel_w) - 1;
   endfunction
endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler
   import tmo_pkg::*;
#(
   parameter int unsigned BASE_SHIFT = 8,
   parameter int unsigned SEL_W      = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   output logic [tap_count(SEL_W)-1:0]    tick
);
   localparam int unsigned NTAP = tap_count(SEL_W);
   localparam int unsigned CW   = prescale_width(BASE_SHIFT, SEL_W);

   generate
      if (BASE_SHIFT < 1) begin : g_bad_base
         $error("tmo_prescaler: BASE_SHIFT must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("tmo_prescaler: SEL_W must be 1 to 4");
      end
   endgenerate

   logic [CW-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc + 1'b1;
   end

   // Tap s fires once every 2^(BASE_SHIFT+s) cycles.
   for (genvar s = 0; s < NTAP; s++) begin : g_tap
      assign tick[s] = &pc[BASE_SHIFT+s-1:0];
      if (s > 0) begin : g_nest
         // A slower tap only fires on a cycle where every faster tap also fires.
         assert_tap_nesting_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick[s] |-> tick[s-1]);
      end
   end
endmodule

// File: rtl/tmo_chan_timer.sv
module tmo_chan_timer #(
   parameter int unsigned PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                armed,
   input  logic                req,
   input  logic                tick,
   input  logic [PERIOD_W-1:0] period,
   input  logic                clr,
   output logic                flag
);
   generate
      if (PERIOD_W < 2) begin : g_bad_w
         $error("tmo_chan_timer: PERIOD_W must be at least 2");
      end
   endgenerate

   logic [PERIOD_W-1:0] cnt;
   logic                expire;

   assign expire = armed && !req && tick && (cnt == PERIOD_W'(1));

   // Countdown: held at the period when idle, reloaded on a request,
   // stepped down on a tick and parked once it reaches zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!armed || req)     cnt <= period;
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
   end

   // Sticky flag: setting wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (expire) flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
   end

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !expire) |=> !flag);
   assert_idle_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !$rose(flag));
   assert_parked_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !req && cnt == '0) |=> (cnt == '0 && !$rose(flag)));
   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && req) |=> !$rose(flag));
endmodule

// File: rtl/tmo_req_monitor.sv
module tmo_req_monitor
   import tmo_pkg::*;
#(
   parameter int unsigned NCH        = 2,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned BASE_SHIFT = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCH-1:0]            cfg_en,
   input  logic [NCH-1:0]            cfg_irq_en,
   input  logic [NCH*SEL_W-1:0]      cfg_psc,
   input  logic [NCH*PERIOD_W-1:0]   cfg_period,
   input  logic [NCH-1:0]            ch_waiting,
   input  logic [NCH-1:0]            periph_req,
   input  logic [NCH-1:0]            flag_clr,
   output logic [NCH-1:0]            tmo_flag,
   output logic                      irq
);
   localparam int unsigned NTAP = tap_count(SEL_W);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("tmo_req_monitor: NCH must be at least 1");
      end
   endgenerate

   logic [NTAP-1:0] tick_vec;

   tmo_prescaler #(
      .BASE_SHIFT (BASE_SHIFT),
      .SEL_W      (SEL_W)
   ) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_vec)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SEL_W-1:0]    sel;
      logic [PERIOD_W-1:0] per;
      logic                armed;
      assign sel   = cfg_psc[c*SEL_W +: SEL_W];
      assign per   = cfg_period[c*PERIOD_W +: PERIOD_W];
      assign armed = cfg_en[c] && ch_waiting[c];

      tmo_chan_timer #(
         .PERIOD_W (PERIOD_W)
      ) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .armed  (armed),
         .req    (periph_req[c]),
         .tick   (tick_vec[sel]),
         .period (per),
         .clr    (flag_clr[c]),
         .flag   (tmo_flag[c])
      );
   end

   assign irq = |(tmo_flag & cfg_irq_en);

   assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|tmo_flag));
   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_irq_en == '0) |-> !irq);
endmodule

// File: tb/tmo_req_monitor_tb.sv
module tmo_req_monitor_tb_top;
   localparam int NCH = 2;
   localparam int SEL_W = 3;
   localparam int PW = 16;
   localparam int BASE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] cfg_en = '0, cfg_irq_en = '0, ch_waiting = '0, periph_req = '0, flag_clr = '0;
   logic [NCH*SEL_W-1:0] cfg_psc = '0;
   logic [NCH*PW-1:0] cfg_period = '0;
   logic [NCH-1:0] tmo_flag;
   logic irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tmo_req_monitor #(.NCH(NCH), .SEL_W(SEL_W), .PERIOD_W(PW), .BASE_SHIFT(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
      .cfg_psc(cfg_psc), .cfg_period(cfg_period), .ch_waiting(ch_waiting),
      .periph_req(periph_req), .flag_clr(flag_clr), .tmo_flag(tmo_flag), .irq(irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // Arm channel c and count edges until its flag rises (0 if not by limit).
   task automatic measure(input int c, input int limit, output int k);
      k = 0;
      cfg_en[c] = 1'b1;
      ch_waiting[c] = 1'b1;
      for (int i = 1; i <= limit; i++) begin
         step();
         if (tmo_flag[c]) begin
            k = i;
            break;
         end
      end
   endtask

   task automatic disarm_clear(input int c);
      cfg_en[c] = 1'b0;
      ch_waiting[c] = 1'b0;
      flag_clr[c] = 1'b1;
      step();
      flag_clr[c] = 1'b0;
      step();
   endtask

   initial begin
      int k, d, lo, hi;
      bit seen;
      repeat (3) step();
      // R1: reset state
      chk(tmo_flag == '0, "R1 flags after reset", int'(tmo_flag), 0);
      chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
      rst_n = 1'b1;
      step();

      // R2: sweep every prescaler select with periods 1..3 on channel 0
      for (int s = 0; s < 8; s++) begin
         for (int p = 1; p <= 3; p++) begin
            cfg_psc[0 +: SEL_W] = SEL_W'(s);
            cfg_period[0 +: PW] = PW'(p);
            step();
            d = 1 << (BASE + s);
            lo = (p - 1) * d + 1;
            hi = p * d;
            measure(0, hi + 4, k);
            chk(k >= lo && k <= hi, $sformatf("R2 expiry edge s=%0d p=%0d", s, p), k, hi);
            // R9: channel 1 untouched
            chk(tmo_flag[1] == 1'b0, "R9 other channel flag", int'(tmo_flag[1]), 0);
            disarm_clear(0);
         end
      end

      // R3: requests every 4 edges with period 2, psc 0 (tick every 4)
      cfg_psc[SEL_W +: SEL_W] = 3'd0;
      cfg_period[PW +: PW] = 16'd2;
      step();
      cfg_en[1] = 1'b1;
      ch_waiting[1] = 1'b1;
      seen = 0;
      for (int i = 0; i < 60; i++) begin
         periph_req[1] = (i % 4 == 0);
         step();
         if (tmo_flag[1]) seen = 1;
      end
      periph_req[1] = 1'b0;
      chk(!seen, "R3 frequent requests prevent expiry", int'(seen), 0);
      measure(1, 12, k);
      chk(k >= 5 && k <= 8, "R3 expiry once requests stop", k, 8);

      // R5: zero clear bit has no effect, one bit clears
      flag_clr = 2'b01;
      step();
      flag_clr = 2'b00;
      chk(tmo_flag[1] == 1'b1, "R5 clear of other bit ignored", int'(tmo_flag[1]), 1);
      flag_clr = 2'b10;
      step();
      flag_clr = 2'b00;
      chk(tmo_flag[1] == 1'b0, "R5 write-one clears flag", int'(tmo_flag[1]), 0);

      // R6: parked at zero, no re-rise while still armed
      seen = 0;
      for (int i = 0; i < 100; i++) begin
         step();
         if (tmo_flag[1]) seen = 1;
      end
      chk(!seen, "R6 no re-rise after clear", int'(seen), 0);
      periph_req[1] = 1'b1;
      step();
      periph_req[1] = 1'b0;
      measure(1, 12, k);
      chk(k >= 5 && k <= 8, "R6 request reloads full period", k, 8);

      // R7: interrupt gating
      chk(irq == 1'b0, "R7 irq masked", int'(irq), 0);
      cfg_irq_en = 2'b01;
      #1;
      chk(irq == 1'b0, "R7 irq wrong channel enable", int'(irq), 0);
      cfg_irq_en = 2'b10;
      #1;
      chk(irq == 1'b1, "R7 irq enabled", int'(irq), 1);
      disarm_clear(1);
      chk(irq == 1'b0, "R7 irq drops with flag", int'(irq), 0);
      cfg_irq_en = '0;

      // R4: enabled but not waiting, and waiting but not enabled
      cfg_psc[0 +: SEL_W] = 3'd0;
      cfg_period[0 +: PW] = 16'd1;
      cfg_en[0] = 1'b1;
      ch_waiting[0] = 1'b0;
      repeat (40) step();
      chk(tmo_flag[0] == 1'b0, "R4 not waiting holds", int'(tmo_flag[0]), 0);
      cfg_en[0] = 1'b0;
      ch_waiting[0] = 1'b1;
      repeat (40) step();
      chk(tmo_flag[0] == 1'b0, "R4 disabled holds", int'(tmo_flag[0]), 0);
      ch_waiting[0] = 1'b0;
      step();

      // R8: zero period never flags
      cfg_period[0 +: PW] = 16'd0;
      step();
      measure(0, 80, k);
      chk(k == 0, "R8 zero period", k, 0);
      disarm_clear(0);

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) chk(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule